// File: doc/BRIEF.md
# Audio DAC Power-Up Sequencer

This controller takes a stereo audio converter from power-on reset to live output. It runs entirely on the master clock. It waits for the left/right word clock to start toggling, then walks through a fixed chain of phases. Each phase switches on one more part of the converter: first the analog section, then the digital core together with the charge pump. A final settling interval follows, and only after it ends is the output unmuted. Until that point the converter is held at zero data.

The settling interval is counted in word-clock periods, and its length grows with the selected sample-rate speed mode. The analog start-up delay and the register-write lockout are counted in master-clock cycles. Each of these lengths is a parameter.

If the word clock stops for too long, the block falls back to power-down and mutes. The power-on reset does the same at any moment. A three-bit state output shows the current phase.

Top module: `dac_pwrseq`

## Requirements
- R1: While `rst_ni` is low, and immediately when it falls at any time, the outputs take their reset values: `state_o` = 0, all three enables = 0, `mute_o` = 1 and `wr_ready_o` = 0. No clock edge is needed.
- R2: `state_o` encodes power-down = 0, analog wait = 1, digital wait = 2, settle = 3 and active = 4. Power-down is held for as long as no rising word-clock edge arrives.
- R3: A rising edge of `wclk_i` that is first sampled at master-clock edge k acts on the sequencer at edge k+2.
- R4: After leaving power-down, the analog wait lasts exactly `ANA_DLY` master-clock cycles. `ana_en_o` then goes high as the state enters digital wait.
- R5: In digital wait, the third counted rising word-clock edge moves the block to settle. At that same edge both `dig_en_o` and `cp_en_o` go high. `ana_en_o` is already high before this point.
- R6: Settle ends on the N-th counted rising word-clock edge. N is `SETTLE_BASE` for `speed_i` = 00, 2×`SETTLE_BASE` for 01, and 4×`SETTLE_BASE` for 10 or 11. `speed_i` is sampled only at the edge that enters settle; later changes have no effect.
- R7: `mute_o` is high in every state except active, and it falls only on the move from settle to active. In active, all three enables are high.
- R8: `wr_ready_o` rises exactly `WR_DLY`+2 master-clock edges after `rst_ni` is released. The two extra edges come from reset synchronisation. It does not depend on the word clock, and it stays high until the next reset.
- R9: In any state other than power-down, `STALL_LIM` consecutive master-clock edges without a counted word-clock edge return the block to power-down. At that point mute goes high and all enables go low.
- R10: The state only ever advances to the next phase or drops to power-down; no phase is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| wclk_i | input | 1 | Left/right word clock, asynchronous to `clk_i` |
| speed_i | input | 2 | Speed mode: 00 normal, 01 double, 1x quad |
| ana_en_o | output | 1 | Analog section enable |
| dig_en_o | output | 1 | Digital core enable |
| cp_en_o | output | 1 | Charge-pump enable |
| mute_o | output | 1 | Force output to zero data |
| wr_ready_o | output | 1 | Register writes may be accepted |
| state_o | output | 3 | Current sequencer phase |

## Verification
The bench times every phase at the cycle level for each speed code, including 11, which must behave as quad. A design that decoded only 10 as quad, or that miscounted the digital wait by one edge, would show a wrong edge count for that phase. It also changes `speed_i` in the middle of settle. A design that kept reading the live pin, instead of the value sampled at entry, would stretch or shorten settle. It measures the stall timeout from the last counted edge, so an off-by-one in the stall counter shows up as a shifted drop to power-down. It also pulses reset during active output, so a synchronous-only reset would leave the output unmuted for a cycle.

// File: rtl/dac_pwrseq_pkg.sv
package dac_pwrseq_pkg;

  typedef enum logic [2:0] {
    SQ_OFF    = 3'd0,
    SQ_ANA    = 3'd1,
    SQ_DIG    = 3'd2,
    SQ_SETTLE = 3'd3,
    SQ_LIVE   = 3'd4
  } seq_state_e;

  // speed code to left-shift of the base settle length: 00 -> 0, 01 -> 1, 1x -> 2
  function automatic int unsigned rate_shift(input logic [1:0] code);
    if (code[1]) return 2;
    else if (code[0]) return 1;
    else return 0;
  endfunction

endpackage

// File: rtl/dac_pwrseq_rstsync.sv
module dac_pwrseq_rstsync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[DEPTH-1];
endmodule

// File: rtl/dac_pwrseq_wsync.sv
module dac_pwrseq_wsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wclk_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], wclk_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dac_pwrseq_wrwin.sv
module dac_pwrseq_wrwin #(
  parameter int unsigned DLY = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned W = $clog2(DLY + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         rdy_q, rdy_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ~rdy_q;
    cnt_d  = cnt_q + 1'b1;
    rdy_d  = (cnt_q == W'(DLY - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/dac_pwrseq.sv
module dac_pwrseq
  import dac_pwrseq_pkg::*;
#(
  parameter int unsigned ANA_DLY     = 492,      // ~20 us of master clock
  parameter int unsigned WR_DLY      = 1228800,  // ~50 ms of master clock
  parameter int unsigned STALL_LIM   = 4096,     // word-clock loss timeout
  parameter int unsigned DIG_EDGES   = 3,
  parameter int unsigned SETTLE_BASE = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wclk_i,
  input  logic [1:0] speed_i,
  output logic       ana_en_o,
  output logic       dig_en_o,
  output logic       cp_en_o,
  output logic       mute_o,
  output logic       wr_ready_o,
  output logic [2:0] state_o
);
  localparam int unsigned SET_MAX = SETTLE_BASE * 4;
  localparam int unsigned PH_A    = (SET_MAX > ANA_DLY) ? SET_MAX : ANA_DLY;
  localparam int unsigned PH_MAX  = (PH_A > DIG_EDGES) ? PH_A : DIG_EDGES;
  localparam int unsigned PW      = $clog2(PH_MAX + 1);
  localparam int unsigned SW      = $clog2(STALL_LIM + 1);

  logic rst_int_n;
  logic rise;

  seq_state_e    st_q, st_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          ph_en;
  logic [SW-1:0] stl_q, stl_d;
  logic [1:0]    rate_q, rate_d;
  logic          rate_en;
  logic [PW-1:0] set_last;
  logic          stall_hit;

  dac_pwrseq_rstsync #(.DEPTH(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  dac_pwrseq_wsync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .wclk_i (wclk_i),
    .rise_o (rise)
  );

  dac_pwrseq_wrwin #(.DLY(WR_DLY)) u_wrwin (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .ready_o (wr_ready_o)
  );

  // settle length from the speed code captured at settle entry
  always_comb begin
    set_last = PW'((SETTLE_BASE << rate_shift(rate_q)) - 1);
  end

  // next-state logic
  always_comb begin
    st_d      = st_q;
    stall_hit = (st_q != SQ_OFF) && !rise && (stl_q == SW'(STALL_LIM - 1));
    unique case (st_q)
      SQ_OFF:    if (rise) st_d = SQ_ANA;
      SQ_ANA:    if (ph_q == PW'(ANA_DLY - 1)) st_d = SQ_DIG;
      SQ_DIG:    if (rise && (ph_q == PW'(DIG_EDGES - 1))) st_d = SQ_SETTLE;
      SQ_SETTLE: if (rise && (ph_q == set_last)) st_d = SQ_LIVE;
      SQ_LIVE:   st_d = SQ_LIVE;
      default:   st_d = SQ_OFF;
    endcase
    if (stall_hit) st_d = SQ_OFF;
  end

  // phase counter: master cycles in analog wait, word edges in later phases
  always_comb begin
    ph_en = (st_d != st_q) || (st_q == SQ_ANA) ||
            (rise && ((st_q == SQ_DIG) || (st_q == SQ_SETTLE)));
    ph_d  = (st_d != st_q) ? '0 : ph_q + 1'b1;
  end

  // word-clock loss counter
  always_comb begin
    stl_d = ((st_q == SQ_OFF) || rise) ? '0 : stl_q + 1'b1;
  end

  // speed capture at settle entry
  always_comb begin
    rate_en = (st_q == SQ_DIG) && (st_d == SQ_SETTLE);
    rate_d  = speed_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= SQ_OFF;
      ph_q   <= '0;
      stl_q  <= '0;
      rate_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      stl_q <= stl_d;
      if (ph_en)   ph_q   <= ph_d;
      if (rate_en) rate_q <= rate_d;
    end
  end

  // output decode
  always_comb begin
    ana_en_o = 1'b0;
    dig_en_o = 1'b0;
    cp_en_o  = 1'b0;
    mute_o   = 1'b1;
    unique case (st_q)
      SQ_DIG:    ana_en_o = 1'b1;
      SQ_SETTLE: begin ana_en_o = 1'b1; dig_en_o = 1'b1; cp_en_o = 1'b1; end
      SQ_LIVE:   begin ana_en_o = 1'b1; dig_en_o = 1'b1; cp_en_o = 1'b1; mute_o = 1'b0; end
      default:   ;
    endcase
    state_o = st_q;
  end

endmodule

// File: rtl/dac_pwrseq_chk.sv
module dac_pwrseq_chk #(
  parameter int unsigned ANA_DLY = 492
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ana_en_o,
  input logic       dig_en_o,
  input logic       cp_en_o,
  input logic       mute_o,
  input logic       wr_ready_o,
  input logic [2:0] state_o
);
  int unsigned wa_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wa_cnt <= 0;
    else if (state_o == 3'd1) wa_cnt <= wa_cnt + 1;
    else                      wa_cnt <= 0;
  end

  p_state_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  p_wa_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) == 3'd1) |-> wa_cnt == ANA_DLY);

  p_ana_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dig_en_o) || $rose(cp_en_o)) |-> ($past(ana_en_o) && $past(state_o) == 3'd2));

  p_unmute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> $past(state_o) == 3'd3);

  p_wr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |=> wr_ready_o);

  p_seq_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> (state_o == 3'd0 || state_o == $past(state_o) + 3'd1));

endmodule

bind dac_pwrseq dac_pwrseq_chk #(.ANA_DLY(ANA_DLY)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ana_en_o   (ana_en_o),
  .dig_en_o   (dig_en_o),
  .cp_en_o    (cp_en_o),
  .mute_o     (mute_o),
  .wr_ready_o (wr_ready_o),
  .state_o    (state_o)
);

// File: tb/dac_pwrseq_bench.sv
`timescale 1ns/1ps
module dac_pwrseq_bench;
  localparam int ANA   = 8;
  localparam int WRD   = 40;
  localparam int STALL = 40;
  localparam int BASE  = 64;
  localparam int ROWS  = 6;
  // speed at start, speed after settle entry, word-clock half period, expected settle edges
  localparam int TBL [ROWS][4] = '{
    '{0, 0, 8, 64}, '{1, 1, 6, 128}, '{2, 2, 4, 256},
    '{3, 3, 5, 256}, '{0, 2, 8, 64}, '{2, 0, 3, 256}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       wclk;
  logic [1:0] speed;
  logic       ana_en, dig_en, cp_en, mute, wr_ready;
  logic [2:0] state;

  dac_pwrseq #(.ANA_DLY(ANA), .WR_DLY(WRD), .STALL_LIM(STALL), .SETTLE_BASE(BASE)) u_dac_pwrseq (
    .clk_i(clk), .rst_ni(rst_n), .wclk_i(wclk), .speed_i(speed),
    .ana_en_o(ana_en), .dig_en_o(dig_en), .cp_en_o(cp_en), .mute_o(mute),
    .wr_ready_o(wr_ready), .state_o(state));

  int errs = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // word-clock generator: toggles every wc_half master cycles, or holds wc_level
  bit wc_run = 1'b0;
  bit wc_level = 1'b0;
  int wc_half = 8;
  int wc_cnt = 0;
  initial begin
    wclk = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (wc_run) begin
        wc_cnt++;
        if (wc_cnt >= wc_half) begin wc_cnt = 0; wclk = ~wclk; end
      end else begin
        wc_cnt = 0;
        wclk = wc_level;
      end
    end
  end

  // phase monitor, from the requirement-level timing (R3: edge acts two edges after sampling)
  logic [2:0] prv;
  bit wprev, sh1, sh2, pulse, seen;
  int wa_len, wd_e, st_e, gap, wa_rec, wd_rec, st_rec, gap_rec, order_err, out_err;
  always @(negedge clk) begin
    if (!rst_n) begin
      prv = 3'd0; wprev = 1'b0; sh1 = 1'b0; sh2 = 1'b0;
      wa_len = 0; wd_e = 0; st_e = 0; gap = 0;
      wa_rec = -1; wd_rec = -1; st_rec = -1; gap_rec = -1;
    end else begin
      pulse = sh2;
      seen  = wclk & ~wprev;
      sh2 = sh1; sh1 = seen; wprev = wclk;
      if (prv == 3'd1) wa_len++;
      if (pulse && prv == 3'd2) wd_e++;
      if (pulse && prv == 3'd3) st_e++;
      if (pulse || prv == 3'd0) gap = 0; else gap++;
      if (state != prv) begin
        if (!(state == 3'd0 || state == prv + 3'd1)) order_err++;
        if (prv == 3'd1) wa_rec = wa_len;
        if (prv == 3'd2) wd_rec = wd_e;
        if (prv == 3'd3) st_rec = st_e;
        if (state == 3'd0) gap_rec = gap;
        if (state == 3'd1) wa_len = 0;
        if (state == 3'd2) wd_e = 0;
        if (state == 3'd3) st_e = 0;
      end
      if (mute != (state != 3'd4)) out_err++;
      if (ana_en != (state >= 3'd2 && state <= 3'd4)) out_err++;
      if (dig_en != (state >= 3'd3 && state <= 3'd4)) out_err++;
      if (cp_en != dig_en) out_err++;
      prv = state;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wc_run = 1'b0; wc_level = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int waited;
    order_err = 0; out_err = 0;
    speed = 2'b00;
    rst_n = 1'b0;
    #1;
    // R1 reset values
    chk("R1", "state in reset", int'(state), 0);
    chk("R1", "mute in reset", int'(mute), 1);
    chk("R1", "enables in reset", int'({ana_en, dig_en, cp_en}), 0);
    chk("R1", "wr_ready in reset", int'(wr_ready), 0);
    tick(3);

    // R8 write window, counted from release
    rst_n = 1'b1;
    tick(WRD + 1);
    chk("R8", "wr_ready one edge early", int'(wr_ready), 0);
    tick(1);
    chk("R8", "wr_ready at WR_DLY+2", int'(wr_ready), 1);
    // R2 power-down holds without word clock
    tick(100);
    chk("R2", "state with idle word clock", int'(state), 0);
    chk("R8", "wr_ready stays high", int'(wr_ready), 1);

    // R3/R4/R9 directed edge timing
    wc_level = 1'b1;
    tick(3);
    chk("R3", "state before edge acts", int'(state), 0);
    tick(1);
    chk("R3", "state when edge acts", int'(state), 1);
    tick(ANA - 1);
    chk("R4", "still in analog wait", int'(state), 1);
    chk("R4", "ana_en before delay", int'(ana_en), 0);
    tick(1);
    chk("R4", "digital wait after ANA_DLY", int'(state), 2);
    chk("R4", "ana_en after delay", int'(ana_en), 1);
    tick(STALL - ANA - 1);
    chk("R9", "no stall one edge early", int'(state), 2);
    tick(1);
    chk("R9", "stall returns to power-down", int'(state), 0);
    chk("R9", "ana_en after stall", int'(ana_en), 0);

    // table of full sequences
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      speed   = 2'(TBL[r][0]);
      wc_half = TBL[r][2];
      wc_run  = 1'b1;
      waited = 0;
      while (state != 3'd3 && waited < 4000) begin tick(1); waited++; end
      speed = 2'(TBL[r][1]);
      waited = 0;
      while (state != 3'd4 && waited < 8000) begin tick(1); waited++; end
      chk("R7", $sformatf("row %0d reached active", r), int'(state), 4);
      chk("R7", $sformatf("row %0d unmuted", r), int'(mute), 0);
      chk("R4", $sformatf("row %0d analog wait length", r), wa_rec, ANA);
      chk("R5", $sformatf("row %0d digital wait edges", r), wd_rec, 3);
      chk("R6", $sformatf("row %0d settle edges", r), st_rec, TBL[r][3]);
      chk("R10", $sformatf("row %0d phase order errors", r), order_err, 0);
      chk("R7", $sformatf("row %0d output/state mismatches", r), out_err, 0);
    end

    // R9 stall from active output
    wc_run = 1'b0; wc_level = 1'b0;
    tick(STALL + 10);
    chk("R9", "state after word clock loss", int'(state), 0);
    chk("R9", "mute after word clock loss", int'(mute), 1);
    chk("R9", "edges from last word edge to drop", gap_rec, STALL);

    // R1 asynchronous reset during active output
    do_reset();
    speed = 2'b00; wc_half = 4; wc_run = 1'b1;
    waited = 0;
    while (state != 3'd4 && waited < 4000) begin tick(1); waited++; end
    chk("R1", "active before reset pulse", int'(state), 4);
    rst_n = 1'b0;
    #0.2;
    chk("R1", "mute without clock edge", int'(mute), 1);
    chk("R1", "enables without clock edge", int'({ana_en, dig_en, cp_en}), 0);
    chk("R1", "state without clock edge", int'(state), 0);
    wc_run = 1'b0;
    tick(2);

    summary();
    $finish;
  end
endmodule